// File: doc/BRIEF.md
# Snoop Response Combining Unit

This unit sits at the far end of the response path of a snoopy write-invalidate coherence fabric. Each snoop placed on the snoop bus carries a small transaction tag and an operation (plain read or read-for-ownership). Every snooping agent answers a fixed number of cycles later, and all agents answer in the same cycle. The unit holds each batch of answers in a per-tag slot. When a remote fabric segment is attached, it also waits for that segment's summarised answer for the same tag. It then broadcasts one combined directive naming the data source, the agents that must invalidate or drop to shared, the state the requester may take, or a retry.

Directives leave strictly in snoop order, one per cycle at most. Remote answers may come back in any order, and even before the local batch. The answer codes are 3 bits wide: 0 nothing held, 1 holds shared, 2 holds exclusive clean, 3 holds modified, 4 retry, 5 home memory for the address; codes 6 and 7 count as nothing held.

Top module: `snoop_resp_combiner`

## Requirements
- R1: While reset is applied and after its release, `cmb_vld` stays 0 until a snoop has been fully combined.
- R2: With `rmt_present` low, the agent answers are sampled exactly LAT clock edges after the edge that accepts the snoop, and the directive for that tag appears with `cmb_vld` high one cycle after that sampling edge, with the same tag and operation.
- R3: A retry code (4) from any local agent, or from the remote segment when `rmt_present` is high, gives `cmb_retry`=1 with `cmb_src_vld`, `cmb_src_rmt`, `cmb_src_id`, `cmb_inval`, `cmb_demote` and `cmb_shared` all 0.
- R4: The data source follows a fixed priority: the lowest-index local agent holding modified data, then a remote modified holder, then the lowest-index local shared or exclusive holder, then a remote shared or exclusive holder, then the lowest-index local home memory, then a remote home memory. `cmb_src_rmt`=1 marks a remote source, with `cmb_src_id`=0. If no candidate exists, `cmb_src_vld`=0.
- R5: For a read-for-ownership (`snp_op`=1), `cmb_inval` has bit i set for every local agent that answered 1, 2 or 3. `cmb_demote` and `cmb_shared` are 0.
- R6: For a read (`snp_op`=0), `cmb_demote` has bit i set for every local agent that answered 2 or 3, and `cmb_inval` is 0. `cmb_shared` is 1 when any local agent, or (with `rmt_present`) the remote segment, answered 1, 2 or 3.
- R7: With `rmt_present` high, no directive leaves before the remote answer for its tag has been sampled. If the local batch is already in, the directive leaves in the cycle after the edge that samples the remote answer.
- R8: Directives leave in the order their snoops were accepted, even when remote answers return out of order. When the older snoop's remote answer arrives last, the younger directive follows in the very next cycle.
- R9: With `rmt_present` low, the remote inputs have no effect on any directive.
- R10: Answer codes 6 and 7 act exactly like code 0.
- R11: Exactly one directive leaves for each accepted snoop, and none leaves without an outstanding snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rmt_present | input | 1 | A remote segment is attached and its answers must be folded in |
| snp_vld | input | 1 | Snoop accepted on the snoop bus this cycle |
| snp_tag | input | TAGW | Tag of the snoop |
| snp_op | input | 1 | 0 read, 1 read-for-ownership |
| rsp_code | input | NAG*3 | Agent answers, agent i in bits [3i+2:3i] |
| rmt_vld | input | 1 | Remote summarised answer present |
| rmt_tag | input | TAGW | Tag of the remote answer |
| rmt_code | input | 3 | Remote summarised answer code |
| cmb_vld | output | 1 | Combined directive valid |
| cmb_tag | output | TAGW | Tag of the directive |
| cmb_op | output | 1 | Operation of the directive |
| cmb_retry | output | 1 | Requester must retry |
| cmb_src_vld | output | 1 | A data source was chosen |
| cmb_src_rmt | output | 1 | Data comes from the remote segment |
| cmb_src_id | output | AW | Local agent that supplies data |
| cmb_inval | output | NAG | Local agents that must invalidate |
| cmb_demote | output | NAG | Local agents that must drop to shared |
| cmb_shared | output | 1 | Requester fills in shared state instead of exclusive |

## Verification
Two things can fall in the same cycle. A batch of local answers lands in its slot while an older tag's directive leaves and frees its own slot. And a remote answer is written for one tag while the head tag is being emitted. Back-to-back snoops under random stimulus with scattered, out-of-order remote answers provoke both; a directed case returns the remote answers in reverse order. Each directive is judged against a bench model for its position in the tag order and for every field, and directed cases pin the exact cycle of emission against the local and the remote sampling edges.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    RSP_NONE  = 3'd0,
    RSP_SHR   = 3'd1,
    RSP_EXC   = 3'd2,
    RSP_MOD   = 3'd3,
    RSP_RETRY = 3'd4,
    RSP_HOME  = 3'd5
  } rsp_code_e;

  localparam logic OP_READ = 1'b0;
  localparam logic OP_OWN  = 1'b1;

  function automatic logic code_holds(input logic [CODE_W-1:0] c);
    return (c == RSP_SHR) || (c == RSP_EXC) || (c == RSP_MOD);
  endfunction

  function automatic logic code_clean(input logic [CODE_W-1:0] c);
    return (c == RSP_SHR) || (c == RSP_EXC);
  endfunction

  function automatic logic code_sole(input logic [CODE_W-1:0] c);
    return (c == RSP_EXC) || (c == RSP_MOD);
  endfunction
endpackage

// File: rtl/scr_snoop_delay.sv
module scr_snoop_delay #(
  parameter int LAT  = 3,
  parameter int TAGW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [TAGW-1:0] in_tag,
  input  logic            in_op,
  output logic            out_vld,
  output logic [TAGW-1:0] out_tag,
  output logic            out_op
);
  logic            vld_q [LAT];
  logic [TAGW-1:0] tag_q [LAT];
  logic            op_q  [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    logic            vld_d;
    logic [TAGW-1:0] tag_d;
    logic            op_d;

    if (g == 0) begin : g_head
      always_comb begin
        vld_d = in_vld;
        tag_d = in_tag;
        op_d  = in_op;
      end
    end else begin : g_body
      always_comb begin
        vld_d = vld_q[g-1];
        tag_d = tag_q[g-1];
        op_d  = op_q[g-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q[g] <= 1'b0;
      else        vld_q[g] <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (vld_d) begin
        tag_q[g] <= tag_d;
        op_q[g]  <= op_d;
      end
    end
  end

  assign out_vld = vld_q[LAT-1];
  assign out_tag = tag_q[LAT-1];
  assign out_op  = op_q[LAT-1];
endmodule

// File: rtl/scr_slot_store.sv
module scr_slot_store import scr_pkg::*; #(
  parameter int NAG  = 4,
  parameter int TAGW = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lw_vld,
  input  logic [TAGW-1:0]         lw_tag,
  input  logic                    lw_op,
  input  logic [NAG*CODE_W-1:0]   lw_rsp,
  input  logic                    rw_vld,
  input  logic [TAGW-1:0]         rw_tag,
  input  logic [CODE_W-1:0]       rw_code,
  input  logic                    pop,
  output logic                    head_vld,
  output logic [TAGW-1:0]         head_tag,
  output logic                    head_op,
  output logic [NAG*CODE_W-1:0]   head_rsp,
  output logic                    head_rdone,
  output logic [CODE_W-1:0]       head_rcode
);
  localparam int NSLOT = 1 << TAGW;

  logic                  slot_op   [NSLOT];
  logic [NAG*CODE_W-1:0] slot_rsp  [NSLOT];
  logic [CODE_W-1:0]     slot_rc   [NSLOT];
  logic [TAGW-1:0]       order_q   [NSLOT];
  logic [NSLOT-1:0]      rdone_q, rdone_d;
  logic [TAGW-1:0]       wptr_q, wptr_d, rptr_q, rptr_d;
  logic [TAGW:0]         cnt_q, cnt_d;

  // order and slot bookkeeping, next state
  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (lw_vld) wptr_d = wptr_q + 1'b1;
    if (pop)    rptr_d = rptr_q + 1'b1;
    case ({lw_vld, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    for (int s = 0; s < NSLOT; s++) begin
      rdone_d[s] = rdone_q[s];
      if (pop && (head_tag == TAGW'(s)))  rdone_d[s] = 1'b0;
      if (rw_vld && (rw_tag == TAGW'(s))) rdone_d[s] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      rdone_q <= '0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      cnt_q   <= cnt_d;
      rdone_q <= rdone_d;
    end
  end

  // payload storage, written under explicit enables, no reset
  always_ff @(posedge clk) begin
    if (lw_vld) begin
      order_q[wptr_q]  <= lw_tag;
      slot_op[lw_tag]  <= lw_op;
      slot_rsp[lw_tag] <= lw_rsp;
    end
    if (rw_vld) slot_rc[rw_tag] <= rw_code;
  end

  assign head_vld   = (cnt_q != '0);
  assign head_tag   = order_q[rptr_q];
  assign head_op    = slot_op[head_tag];
  assign head_rsp   = slot_rsp[head_tag];
  assign head_rdone = rdone_q[head_tag];
  assign head_rcode = slot_rc[head_tag];
endmodule

// File: rtl/scr_merge.sv
module scr_merge import scr_pkg::*; #(
  parameter int NAG = 4,
  parameter int AW  = 2
) (
  input  logic                  op,
  input  logic [NAG*CODE_W-1:0] rsp,
  input  logic [CODE_W-1:0]     rcode,
  input  logic                  use_rmt,
  output logic                  retry,
  output logic                  src_vld,
  output logic                  src_rmt,
  output logic [AW-1:0]         src_id,
  output logic [NAG-1:0]        inval,
  output logic [NAG-1:0]        demote,
  output logic                  shared
);
  logic              loc_retry, hit_mod, hit_cln, hit_home;
  logic [AW-1:0]     id_mod, id_cln, id_home;
  logic [NAG-1:0]    hold, sole;
  logic [CODE_W-1:0] c;
  logic              r_retry, r_mod, r_cln, r_home, r_hold;

  // scan agents from the top down so the lowest index is kept
  always_comb begin
    loc_retry = 1'b0;
    hit_mod   = 1'b0;
    hit_cln   = 1'b0;
    hit_home  = 1'b0;
    id_mod    = '0;
    id_cln    = '0;
    id_home   = '0;
    hold      = '0;
    sole      = '0;
    c         = '0;
    for (int i = NAG - 1; i >= 0; i--) begin
      c = rsp[i*CODE_W +: CODE_W];
      hold[i] = code_holds(c);
      sole[i] = code_sole(c);
      if (c == RSP_RETRY) loc_retry = 1'b1;
      if (c == RSP_MOD)  begin hit_mod  = 1'b1; id_mod  = AW'(i); end
      if (code_clean(c)) begin hit_cln  = 1'b1; id_cln  = AW'(i); end
      if (c == RSP_HOME) begin hit_home = 1'b1; id_home = AW'(i); end
    end
  end

  always_comb begin
    r_retry = use_rmt && (rcode == RSP_RETRY);
    r_mod   = use_rmt && (rcode == RSP_MOD);
    r_cln   = use_rmt && code_clean(rcode);
    r_home  = use_rmt && (rcode == RSP_HOME);
    r_hold  = use_rmt && code_holds(rcode);
  end

  always_comb begin
    retry   = loc_retry || r_retry;
    src_vld = 1'b0;
    src_rmt = 1'b0;
    src_id  = '0;
    inval   = '0;
    demote  = '0;
    shared  = 1'b0;
    if (!retry) begin
      if (hit_mod) begin
        src_vld = 1'b1; src_id = id_mod;
      end else if (r_mod) begin
        src_vld = 1'b1; src_rmt = 1'b1;
      end else if (hit_cln) begin
        src_vld = 1'b1; src_id = id_cln;
      end else if (r_cln) begin
        src_vld = 1'b1; src_rmt = 1'b1;
      end else if (hit_home) begin
        src_vld = 1'b1; src_id = id_home;
      end else if (r_home) begin
        src_vld = 1'b1; src_rmt = 1'b1;
      end
      if (op == OP_OWN) begin
        inval = hold;
      end else begin
        demote = sole;
        shared = (|hold) || r_hold;
      end
    end
  end
endmodule

// File: rtl/snoop_resp_combiner.sv
module snoop_resp_combiner import scr_pkg::*; #(
  parameter int NAG  = 4,
  parameter int TAGW = 2,
  parameter int LAT  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rmt_present,
  input  logic                  snp_vld,
  input  logic [TAGW-1:0]       snp_tag,
  input  logic                  snp_op,
  input  logic [NAG*3-1:0]      rsp_code,
  input  logic                  rmt_vld,
  input  logic [TAGW-1:0]       rmt_tag,
  input  logic [2:0]            rmt_code,
  output logic                  cmb_vld,
  output logic [TAGW-1:0]       cmb_tag,
  output logic                  cmb_op,
  output logic                  cmb_retry,
  output logic                  cmb_src_vld,
  output logic                  cmb_src_rmt,
  output logic [$clog2(NAG)-1:0] cmb_src_id,
  output logic [NAG-1:0]        cmb_inval,
  output logic [NAG-1:0]        cmb_demote,
  output logic                  cmb_shared
);
  localparam int AW = $clog2(NAG);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic                  arr_vld, arr_op;
  logic [TAGW-1:0]       arr_tag;
  logic                  rmt_wr;
  logic                  head_vld, head_op, head_rdone;
  logic [TAGW-1:0]       head_tag;
  logic [NAG*CODE_W-1:0] head_rsp;
  logic [CODE_W-1:0]     head_rcode;
  logic                  emit;
  logic                  m_retry, m_src_vld, m_src_rmt, m_shared;
  logic [AW-1:0]         m_src_id;
  logic [NAG-1:0]        m_inval, m_demote;

  scr_snoop_delay #(.LAT(LAT), .TAGW(TAGW)) u_dly (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .in_vld  (snp_vld),
    .in_tag  (snp_tag),
    .in_op   (snp_op),
    .out_vld (arr_vld),
    .out_tag (arr_tag),
    .out_op  (arr_op)
  );

  assign rmt_wr = rmt_vld && rmt_present;

  scr_slot_store #(.NAG(NAG), .TAGW(TAGW)) u_store (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .lw_vld     (arr_vld),
    .lw_tag     (arr_tag),
    .lw_op      (arr_op),
    .lw_rsp     (rsp_code),
    .rw_vld     (rmt_wr),
    .rw_tag     (rmt_tag),
    .rw_code    (rmt_code),
    .pop        (emit),
    .head_vld   (head_vld),
    .head_tag   (head_tag),
    .head_op    (head_op),
    .head_rsp   (head_rsp),
    .head_rdone (head_rdone),
    .head_rcode (head_rcode)
  );

  scr_merge #(.NAG(NAG), .AW(AW)) u_merge (
    .op      (head_op),
    .rsp     (head_rsp),
    .rcode   (head_rcode),
    .use_rmt (rmt_present),
    .retry   (m_retry),
    .src_vld (m_src_vld),
    .src_rmt (m_src_rmt),
    .src_id  (m_src_id),
    .inval   (m_inval),
    .demote  (m_demote),
    .shared  (m_shared)
  );

  assign emit = head_vld && (head_rdone || !rmt_present);

  // directive register
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) cmb_vld <= 1'b0;
    else             cmb_vld <= emit;
  end

  always_ff @(posedge clk) begin
    if (emit) begin
      cmb_tag     <= head_tag;
      cmb_op      <= head_op;
      cmb_retry   <= m_retry;
      cmb_src_vld <= m_src_vld;
      cmb_src_rmt <= m_src_rmt;
      cmb_src_id  <= m_src_id;
      cmb_inval   <= m_inval;
      cmb_demote  <= m_demote;
      cmb_shared  <= m_shared;
    end
  end
endmodule

// File: rtl/scr_checker.sv
module scr_checker #(
  parameter int NAG  = 4,
  parameter int TAGW = 2,
  parameter int AW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rmt_present,
  input logic            snp_vld,
  input logic            cmb_vld,
  input logic            cmb_op,
  input logic            cmb_retry,
  input logic            cmb_src_vld,
  input logic            cmb_src_rmt,
  input logic [AW-1:0]   cmb_src_id,
  input logic [NAG-1:0]  cmb_inval,
  input logic [NAG-1:0]  cmb_demote,
  input logic            cmb_shared
);
  logic [TAGW+1:0] outst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst_q <= '0;
    else        outst_q <= outst_q + (snp_vld ? 1'b1 : 1'b0) - (cmb_vld ? 1'b1 : 1'b0);
  end

  a_r3_retry_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (cmb_vld && cmb_retry) |-> (!cmb_src_vld && !cmb_src_rmt && cmb_inval == '0
                                && cmb_demote == '0 && !cmb_shared));

  a_r4_rmt_src_id: assert property (@(posedge clk) disable iff (!rst_n)
    (cmb_vld && cmb_src_rmt) |-> (cmb_src_vld && cmb_src_id == '0));

  a_r5_own_actions: assert property (@(posedge clk) disable iff (!rst_n)
    (cmb_vld && cmb_op) |-> (cmb_demote == '0 && !cmb_shared));

  a_r6_read_no_inval: assert property (@(posedge clk) disable iff (!rst_n)
    (cmb_vld && !cmb_op) |-> (cmb_inval == '0));

  a_r9_no_rmt_src: assert property (@(posedge clk) disable iff (!rst_n)
    (cmb_vld && !rmt_present) |-> !cmb_src_rmt);

  a_r11_no_orphan: assert property (@(posedge clk) disable iff (!rst_n)
    cmb_vld |-> (outst_q != '0));
endmodule

bind snoop_resp_combiner scr_checker #(.NAG(NAG), .TAGW(TAGW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rmt_present (rmt_present),
  .snp_vld     (snp_vld),
  .cmb_vld     (cmb_vld),
  .cmb_op      (cmb_op),
  .cmb_retry   (cmb_retry),
  .cmb_src_vld (cmb_src_vld),
  .cmb_src_rmt (cmb_src_rmt),
  .cmb_src_id  (cmb_src_id),
  .cmb_inval   (cmb_inval),
  .cmb_demote  (cmb_demote),
  .cmb_shared  (cmb_shared)
);

// File: tb/tb_snoop_resp_combiner.sv
module tb_snoop_resp_combiner;
  localparam int CLK_PERIOD = 10;
  localparam int NAG   = 4;
  localparam int TAGW  = 2;
  localparam int LAT   = 3;
  localparam int NSLOT = 1 << TAGW;

  logic clk = 1'b0;
  logic rst_n;
  logic rmt_present;
  logic snp_vld;
  logic [TAGW-1:0] snp_tag;
  logic snp_op;
  logic [NAG*3-1:0] rsp_code;
  logic rmt_vld;
  logic [TAGW-1:0] rmt_tag;
  logic [2:0] rmt_code;
  logic cmb_vld, cmb_op, cmb_retry, cmb_src_vld, cmb_src_rmt, cmb_shared;
  logic [TAGW-1:0] cmb_tag;
  logic [1:0] cmb_src_id;
  logic [NAG-1:0] cmb_inval, cmb_demote;

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_resp_combiner #(.NAG(NAG), .TAGW(TAGW), .LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .rmt_present(rmt_present),
    .snp_vld(snp_vld), .snp_tag(snp_tag), .snp_op(snp_op), .rsp_code(rsp_code),
    .rmt_vld(rmt_vld), .rmt_tag(rmt_tag), .rmt_code(rmt_code),
    .cmb_vld(cmb_vld), .cmb_tag(cmb_tag), .cmb_op(cmb_op), .cmb_retry(cmb_retry),
    .cmb_src_vld(cmb_src_vld), .cmb_src_rmt(cmb_src_rmt), .cmb_src_id(cmb_src_id),
    .cmb_inval(cmb_inval), .cmb_demote(cmb_demote), .cmb_shared(cmb_shared)
  );

  int total = 0, bad = 0, cycnt = 0, wd = 0;
  bit done = 0;
  bit rp = 0;

  logic [NAG*3-1:0] e_rsp [NSLOT];
  bit   e_op [NSLOT];
  logic [2:0] e_rc [NSLOT];
  bit   e_rs [NSLOT];
  int   iss_cyc [NSLOT], em_cyc [NSLOT], rm_cyc [NSLOT];
  int   order_q [$];
  int   outst = 0, next_tag = 0, n_iss = 0, n_em = 0;
  bit   pv [LAT+1];
  int   pt [LAT+1];

  bit q_snp, q_op, q_rm;
  logic [NAG*3-1:0] q_rsp;
  int q_rtag;
  logic [2:0] q_rcode;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected directive: {retry, src_vld, src_rmt, src_id[1:0], inval[3:0], demote[3:0], shared}
  function automatic logic [13:0] model(bit op, logic [NAG*3-1:0] r, logic [2:0] rc, bit use_r);
    bit rty = 0;
    int ms = -1, cs = -1, hs = -1;
    logic [3:0] hold = '0, sole = '0;
    bit rhold;
    logic [3:0] srcf;
    logic [2:0] c;
    for (int i = 0; i < NAG; i++) begin
      c = r[3*i +: 3];
      if (c == 3'd4) rty = 1;
      if (c == 3'd3 && ms < 0) ms = i;
      if ((c == 3'd1 || c == 3'd2) && cs < 0) cs = i;
      if (c == 3'd5 && hs < 0) hs = i;
      if (c == 3'd1 || c == 3'd2 || c == 3'd3) hold[i] = 1'b1;
      if (c == 3'd2 || c == 3'd3) sole[i] = 1'b1;
    end
    if (use_r && rc == 3'd4) rty = 1;
    if (rty) return 14'b10_0000_0000_0000;
    rhold = use_r && (rc == 3'd1 || rc == 3'd2 || rc == 3'd3);
    if (ms >= 0)                                srcf = {2'b10, 2'(ms)};
    else if (use_r && rc == 3'd3)               srcf = 4'b1100;
    else if (cs >= 0)                           srcf = {2'b10, 2'(cs)};
    else if (use_r && (rc == 3'd1 || rc == 3'd2)) srcf = 4'b1100;
    else if (hs >= 0)                           srcf = {2'b10, 2'(hs)};
    else if (use_r && rc == 3'd5)               srcf = 4'b1100;
    else                                        srcf = 4'b0000;
    return {1'b0, srcf, (op ? hold : 4'b0), (op ? 4'b0 : sole), (!op && ((|hold) || rhold))};
  endfunction

  task automatic observe();
    int t;
    logic [13:0] act, exp;
    if (order_q.size() == 0) begin
      chk(0, "R11 orphan directive", 32'(cmb_tag), 0);
      return;
    end
    t = order_q.pop_front();
    chk(cmb_tag == TAGW'(t), "R8 tag order", 32'(cmb_tag), 32'(t));
    chk(cmb_op == e_op[t], "R2 op echo", 32'(cmb_op), 32'(e_op[t]));
    chk(!rp || e_rs[t], "R7 left before remote answer", 0, 1);
    act = {cmb_retry, cmb_src_vld, cmb_src_rmt, cmb_src_id, cmb_inval, cmb_demote, cmb_shared};
    exp = model(e_op[t], e_rsp[t], e_rc[t], rp);
    if (exp[13]) chk(act == exp, "R3 retry directive", 32'(act), 32'(exp));
    else begin
      chk(act[13] == 1'b0, "R3 no false retry", 32'(act), 32'(exp));
      chk(act[12:9] == exp[12:9], "R4 source select", 32'(act[12:9]), 32'(exp[12:9]));
      if (e_op[t]) chk(act[8:0] == exp[8:0], "R5 ownership actions", 32'(act[8:0]), 32'(exp[8:0]));
      else         chk(act[8:0] == exp[8:0], "R6 read actions", 32'(act[8:0]), 32'(exp[8:0]));
    end
    em_cyc[t] = cycnt;
    outst--;
    n_em++;
  endtask

  task automatic cyc();
    int tg;
    for (int i = LAT; i > 0; i--) begin pv[i] = pv[i-1]; pt[i] = pt[i-1]; end
    pv[0] = 0;
    rmt_vld  = q_rm;
    rmt_tag  = TAGW'(q_rtag);
    rmt_code = q_rcode;
    if (q_rm && rp) begin
      e_rc[q_rtag] = q_rcode;
      e_rs[q_rtag] = 1;
      rm_cyc[q_rtag] = cycnt + 1;
    end
    if (q_snp) begin
      tg = next_tag;
      e_op[tg] = q_op; e_rsp[tg] = q_rsp; e_rs[tg] = 0;
      iss_cyc[tg] = cycnt + 1;
      order_q.push_back(tg);
      outst++; n_iss++;
      next_tag = (next_tag + 1) % NSLOT;
      pv[0] = 1; pt[0] = tg;
      snp_vld = 1; snp_tag = TAGW'(tg); snp_op = q_op;
    end else begin
      snp_vld = 0; snp_tag = TAGW'($urandom); snp_op = 1'($urandom);
    end
    rsp_code = pv[LAT] ? e_rsp[pt[LAT]] : '0;
    q_snp = 0; q_rm = 0;
    @(negedge clk);
    cycnt++;
    if (cmb_vld) observe();
  endtask

  task automatic issue(bit op, logic [NAG*3-1:0] r);
    q_snp = 1; q_op = op; q_rsp = r;
    cyc();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic send_rmt(int tg, logic [2:0] code);
    q_rm = 1; q_rtag = tg; q_rcode = code;
    cyc();
  endtask

  function automatic logic [NAG*3-1:0] rnd_rsp();
    logic [NAG*3-1:0] r;
    int k;
    for (int i = 0; i < NAG; i++) begin
      k = $urandom % 20;
      if (k < 8)       r[3*i +: 3] = 3'd0;
      else if (k < 10) r[3*i +: 3] = 3'd1;
      else if (k < 12) r[3*i +: 3] = 3'd2;
      else if (k < 13) r[3*i +: 3] = 3'd3;
      else if (k < 14) r[3*i +: 3] = 3'd4;
      else if (k < 16) r[3*i +: 3] = 3'd5;
      else             r[3*i +: 3] = 3'(6 + (k & 1));
    end
    return r;
  endfunction

  task automatic pick_remote();
    int cand [$];
    int tg;
    for (int i = 0; i < order_q.size(); i++) if (!e_rs[order_q[i]]) cand.push_back(order_q[i]);
    if (cand.size() == 0) return;
    tg = cand[$urandom % cand.size()];
    q_rm = 1; q_rtag = tg; q_rcode = 3'($urandom % 8);
  endtask

  task automatic random_run(int ncyc);
    for (int n = 0; n < ncyc; n++) begin
      if (rp) begin
        if ($urandom % 3 == 0) pick_remote();
      end else if ($urandom % 2 == 0) begin
        q_rm = 1; q_rtag = $urandom % NSLOT; q_rcode = 3'($urandom);
      end
      if (outst < NSLOT && ($urandom % 3 != 0)) begin
        q_snp = 1; q_op = 1'($urandom); q_rsp = rnd_rsp();
      end
      cyc();
    end
    for (int g = 0; g < 400 && outst > 0; g++) begin
      if (rp) pick_remote();
      cyc();
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ta, tb2;
    void'($urandom(32'h1c0de5));
    for (int i = 0; i <= LAT; i++) begin pv[i] = 0; pt[i] = 0; end
    q_snp = 0; q_rm = 0; q_op = 0; q_rsp = '0; q_rtag = 0; q_rcode = '0;
    rst_n = 1'b0; rmt_present = 1'b0; snp_vld = 0; snp_tag = '0; snp_op = 0;
    rsp_code = '0; rmt_vld = 0; rmt_tag = '0; rmt_code = '0;
    repeat (3) @(negedge clk);
    chk(cmb_vld == 1'b0, "R1 idle in reset", 32'(cmb_vld), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cmb_vld == 1'b0, "R1 idle after reset", 32'(cmb_vld), 0);

    // read: agent0 shared, agent2 modified, agent3 home -> agent2 supplies
    rp = 0; rmt_present = 0;
    ta = next_tag;
    issue(1'b0, {3'd5, 3'd3, 3'd0, 3'd1});
    idle(LAT + 2);
    chk(em_cyc[ta] == iss_cyc[ta] + LAT + 1, "R2 fixed latency", 32'(em_cyc[ta] - iss_cyc[ta]), LAT + 1);

    // retry from agent1 beats a modified agent0
    issue(1'b1, {3'd0, 3'd0, 3'd4, 3'd3});
    idle(LAT + 2);
    // codes 6 and 7 act as nothing held: home at agent3 supplies
    issue(1'b0, {3'd5, 3'd7, 3'd6, 3'd6});
    idle(LAT + 2);
    chk(n_em == 3, "R10 all directives seen", 32'(n_em), 3);

    // remote inputs ignored when no remote segment: remote retry and modified sent
    ta = next_tag;
    q_rm = 1; q_rtag = ta; q_rcode = 3'd4;
    issue(1'b1, {3'd1, 3'd0, 3'd2, 3'd0});
    send_rmt(ta, 3'd3);
    idle(LAT + 2);
    chk(em_cyc[ta] == iss_cyc[ta] + LAT + 1, "R9 timing unaffected", 32'(em_cyc[ta] - iss_cyc[ta]), LAT + 1);

    // remote segment attached: directive waits for late remote answer
    rp = 1; rmt_present = 1;
    ta = next_tag;
    issue(1'b0, {3'd0, 3'd0, 3'd0, 3'd5});
    idle(LAT + 4);
    chk(n_em == 4, "R7 held until remote", 32'(n_em), 4);
    send_rmt(ta, 3'd3);
    idle(2);
    chk(em_cyc[ta] == rm_cyc[ta] + 1, "R7 release cycle", 32'(em_cyc[ta] - rm_cyc[ta]), 1);

    // remote retry with local modified holder
    ta = next_tag;
    issue(1'b1, {3'd3, 3'd0, 3'd0, 3'd0});
    send_rmt(ta, 3'd4);
    idle(LAT + 2);

    // out-of-order remote answers
    ta = next_tag;
    issue(1'b0, {3'd0, 3'd0, 3'd1, 3'd0});
    tb2 = next_tag;
    issue(1'b1, {3'd2, 3'd0, 3'd0, 3'd0});
    idle(LAT + 2);
    send_rmt(tb2, 3'd0);
    send_rmt(ta, 3'd1);
    idle(3);
    chk(em_cyc[ta] == rm_cyc[ta] + 1, "R8 older leaves first", 32'(em_cyc[ta] - rm_cyc[ta]), 1);
    chk(em_cyc[tb2] == em_cyc[ta] + 1, "R8 younger follows", 32'(em_cyc[tb2] - em_cyc[ta]), 1);

    rp = 1; rmt_present = 1;
    random_run(3000);
    rp = 0; rmt_present = 0;
    idle(2);
    random_run(3000);

    chk(outst == 0, "R11 nothing outstanding", 32'(outst), 0);
    chk(n_em == n_iss, "R11 one directive per snoop", 32'(n_em), 32'(n_iss));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule